// File: doc/BRIEF.md
# Reservation Monitor for Split Atomic Load/Store Pairs

This block gives several harts a shared, word-addressed memory that supports a two-step atomic update. A hart first issues a load-reserved. It gets back the current word and takes a reservation on the block that holds it. Later the hart issues a store-conditional to the same block. The write lands only if nothing has disturbed the reservation in the meantime. The response tells the hart whether the pair behaved atomically, so software can retry a failed attempt in a loop.

Each hart has its own request slot and may issue one operation per cycle. Four events break a reservation: a write to the block by any agent, an interrupt or context switch on the owning hart, an external invalidation of the block, and the hart's own store-conditional. When several harts try to commit to one block in the same cycle, a fixed priority decides which one wins. Block granularity comes from a parameter that sets how many low address bits are ignored when addresses are compared.

Top module: `lrsc_monitor`

## Requirements
- R1: A load-reserved (operation code 2'b10) returns, one cycle after the request, the word held at its address before any write made in that cycle. A plain load (2'b00) does the same.
- R2: A store-conditional (2'b11) by a hart that still holds a valid reservation on the same block writes its data and returns 0 one cycle after the request.
- R3: A store-conditional without a valid reservation on its block returns the failure code 1 and leaves memory unchanged. This covers the case right after reset, when no reservation exists.
- R4: Reservation matching ignores the low BLK_BITS address bits. The block number is the address shifted right by BLK_BITS.
- R5: A plain store (2'b01) or a successful store-conditional by another hart to the reserved block clears the reservation, so the owner's next store-conditional fails.
- R6: A pulse on a hart's clear input (interrupt, exception or context switch) clears that hart's reservation. A store-conditional in the same cycle as the pulse fails.
- R7: An invalidation whose block number matches clears the reservation. An invalidation of a different block leaves the reservation intact.
- R8: A store-conditional clears the issuing hart's reservation whether it succeeds or fails, so a second store-conditional fails.
- R9: When several harts with valid reservations issue a store-conditional to one block in the same cycle, the lowest-numbered hart succeeds and all the others return 1.
- R10: A plain store from a hart to its own reserved block clears its own reservation.
- R11: A load-reserved performs no write. The word reads back unchanged afterwards.
- R12: Every accepted request raises resp_valid for its hart exactly one cycle later. After reset, resp_valid is low. A plain store returns data 0.
- R13: A plain store to a block clears, in the same cycle, the chance of any store-conditional to that block. When several plain stores hit one word in the same cycle, the lowest-numbered hart's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | HARTS | Request strobe, one bit per hart |
| req_op | input | 2*HARTS | Operation per hart: 00 load, 01 store, 10 load-reserved, 11 store-conditional |
| req_addr | input | AW*HARTS | Word address per hart |
| req_wdata | input | DW*HARTS | Write data per hart |
| hart_clear | input | HARTS | Interrupt or context-switch pulse per hart |
| inval_valid | input | 1 | External block invalidation strobe |
| inval_blk | input | AW-BLK_BITS | Block number being invalidated |
| resp_valid | output | HARTS | Response strobe per hart, one cycle after the request |
| resp_data | output | DW*HARTS | Loaded word, store-conditional code (0 or 1), or 0 for a store |

## Verification
A sweep over every hart and every word pairs a store, a load-reserved, a store-conditional and a load. It separates correct read data from correct commit data, and shows that an undisturbed pair always succeeds. A second sweep takes every ordered pair of harts and every word offset inside a block, with a foreign store placed between the reserve and the commit. It separates block-granular clearing from word-granular clearing, because the foreign store may hit a different word of the same block. Directed same-cycle patterns then separate the event priorities from each other: competing commits, a store racing a commit, a clear pulse or an invalidation alongside a commit, and a commit repeated after an earlier one.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LR    = 2'b10,
    OP_SC    = 2'b11
  } op_e;

  localparam int unsigned SC_FAIL_CODE = 1;
endpackage

// File: rtl/lrsc_arbiter.sv
// Decides which store-conditionals commit this cycle and which harts write.
module lrsc_arbiter #(
  parameter int HARTS = 4,
  parameter int BAW   = 4
) (
  input  logic [HARTS-1:0]          is_st,
  input  logic [HARTS-1:0]          is_sc,
  input  logic [HARTS-1:0]          resv_hit,
  input  logic [HARTS-1:0]          clr,
  input  logic                      inval_v,
  input  logic [BAW-1:0]            inval_blk,
  input  logic [HARTS-1:0][BAW-1:0] blk,
  output logic [HARTS-1:0]          sc_win,
  output logic [HARTS-1:0]          wr_en
);
  logic [HARTS-1:0] cand;

  // A commit is a candidate if its reservation survives every event of this cycle
  always_comb begin
    for (int h = 0; h < HARTS; h++) begin
      cand[h] = is_sc[h] && resv_hit[h] && !clr[h] &&
                !(inval_v && (inval_blk == blk[h]));
      for (int g = 0; g < HARTS; g++) begin
        if (is_st[g] && (blk[g] == blk[h])) cand[h] = 1'b0;
      end
    end
  end

  // Fixed priority: lower hart index beats higher on the same block
  always_comb begin
    for (int h = 0; h < HARTS; h++) begin
      sc_win[h] = cand[h];
      for (int g = 0; g < h; g++) begin
        if (cand[g] && (blk[g] == blk[h])) sc_win[h] = 1'b0;
      end
    end
  end

  assign wr_en = is_st | sc_win;
endmodule

// File: rtl/lrsc_resv.sv
// One hart's reservation register with its clearing rules.
module lrsc_resv #(
  parameter int HARTS = 4,
  parameter int BAW   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      is_lr,
  input  logic                      is_sc,
  input  logic [BAW-1:0]            my_blk,
  input  logic                      clr,
  input  logic                      inval_v,
  input  logic [BAW-1:0]            inval_blk,
  input  logic [HARTS-1:0]          wr_en,
  input  logic [HARTS-1:0][BAW-1:0] blk,
  output logic                      resv_v,
  output logic [BAW-1:0]            resv_blk
);
  logic [BAW-1:0] target;
  logic           hit_wr;
  logic           kill;

  assign target = is_lr ? my_blk : resv_blk;

  always_comb begin
    hit_wr = 1'b0;
    for (int g = 0; g < HARTS; g++) begin
      if (wr_en[g] && (blk[g] == target)) hit_wr = 1'b1;
    end
  end

  assign kill = clr || (inval_v && (inval_blk == target)) || hit_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      resv_v   <= 1'b0;
      resv_blk <= '0;
    end else begin
      if (is_lr) resv_blk <= my_blk;
      if (kill || is_sc) resv_v <= 1'b0;
      else if (is_lr)    resv_v <= 1'b1;
    end
  end
endmodule

// File: rtl/lrsc_mem.sv
// Shared word memory: one read and one write port per hart, read-before-write.
module lrsc_mem #(
  parameter int HARTS = 4,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic [HARTS-1:0][AW-1:0] addr,
  input  logic [HARTS-1:0]         wr_en,
  input  logic [HARTS-1:0][DW-1:0] wdata,
  output logic [HARTS-1:0][DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Descending order: the lowest hart's write is the last assignment and wins
  always_ff @(posedge clk) begin
    for (int h = HARTS - 1; h >= 0; h--) begin
      if (wr_en[h]) mem[addr[h]] <= wdata[h];
    end
  end

  always_ff @(posedge clk) begin
    for (int h = 0; h < HARTS; h++) rdata[h] <= mem[addr[h]];
  end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int HARTS    = 4,
  parameter int AW       = 6,
  parameter int DW       = 32,
  parameter int BLK_BITS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [HARTS-1:0]        req_valid,
  input  logic [2*HARTS-1:0]      req_op,
  input  logic [AW*HARTS-1:0]     req_addr,
  input  logic [DW*HARTS-1:0]     req_wdata,
  input  logic [HARTS-1:0]        hart_clear,
  input  logic                    inval_valid,
  input  logic [AW-BLK_BITS-1:0]  inval_blk,
  output logic [HARTS-1:0]        resp_valid,
  output logic [DW*HARTS-1:0]     resp_data
);
  localparam int BAW = AW - BLK_BITS;

  logic [HARTS-1:0][AW-1:0]  addr;
  logic [HARTS-1:0][DW-1:0]  wdata;
  logic [HARTS-1:0][BAW-1:0] blk;
  logic [HARTS-1:0][1:0]     opc;
  logic [HARTS-1:0]          is_st, is_sc, is_lr;
  logic [HARTS-1:0]          resv_v, resv_hit;
  logic [HARTS-1:0][BAW-1:0] resv_blk;
  logic [HARTS-1:0]          sc_win, wr_en;
  logic [HARTS-1:0][DW-1:0]  rdata;
  logic [HARTS-1:0][1:0]     kind_q;
  logic [HARTS-1:0]          fail_q;

  for (genvar h = 0; h < HARTS; h++) begin : g_unpack
    assign addr[h]     = req_addr[h*AW +: AW];
    assign wdata[h]    = req_wdata[h*DW +: DW];
    assign opc[h]      = req_op[2*h +: 2];
    assign blk[h]      = addr[h][AW-1:BLK_BITS];
    assign is_st[h]    = req_valid[h] && (opc[h] == OP_STORE);
    assign is_sc[h]    = req_valid[h] && (opc[h] == OP_SC);
    assign is_lr[h]    = req_valid[h] && (opc[h] == OP_LR);
    assign resv_hit[h] = resv_v[h] && (resv_blk[h] == blk[h]);

    lrsc_resv #(.HARTS(HARTS), .BAW(BAW)) u_resv (
      .clk       (clk),
      .rst       (rst),
      .is_lr     (is_lr[h]),
      .is_sc     (is_sc[h]),
      .my_blk    (blk[h]),
      .clr       (hart_clear[h]),
      .inval_v   (inval_valid),
      .inval_blk (inval_blk),
      .wr_en     (wr_en),
      .blk       (blk),
      .resv_v    (resv_v[h]),
      .resv_blk  (resv_blk[h])
    );
  end

  lrsc_arbiter #(.HARTS(HARTS), .BAW(BAW)) u_arb (
    .is_st     (is_st),
    .is_sc     (is_sc),
    .resv_hit  (resv_hit),
    .clr       (hart_clear),
    .inval_v   (inval_valid),
    .inval_blk (inval_blk),
    .blk       (blk),
    .sc_win    (sc_win),
    .wr_en     (wr_en)
  );

  lrsc_mem #(.HARTS(HARTS), .AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .addr  (addr),
    .wr_en (wr_en),
    .wdata (wdata),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= '0;
      kind_q     <= '0;
      fail_q     <= '0;
    end else begin
      resp_valid <= req_valid;
      kind_q     <= opc;
      fail_q     <= ~sc_win;
    end
  end

  for (genvar h = 0; h < HARTS; h++) begin : g_resp
    always_comb begin
      case (kind_q[h])
        OP_SC:    resp_data[h*DW +: DW] = fail_q[h] ? DW'(SC_FAIL_CODE) : '0;
        OP_STORE: resp_data[h*DW +: DW] = '0;
        default:  resp_data[h*DW +: DW] = rdata[h];
      endcase
    end
  end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int HARTS    = 4,
  parameter int AW       = 6,
  parameter int DW       = 32,
  parameter int BLK_BITS = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [HARTS-1:0]     req_valid,
  input logic [2*HARTS-1:0]   req_op,
  input logic [AW*HARTS-1:0]  req_addr,
  input logic [HARTS-1:0]     hart_clear,
  input logic [HARTS-1:0]     resp_valid,
  input logic [DW*HARTS-1:0]  resp_data,
  input logic [HARTS-1:0]     sc_win,
  input logic [HARTS-1:0]     resv_v
);
  for (genvar h = 0; h < HARTS; h++) begin : g_h
    assert_resp_follows_R12: assert property (@(posedge clk) disable iff (rst)
      req_valid[h] |=> resp_valid[h]) else $error("R12 missing response");

    assert_no_spurious_resp_R12: assert property (@(posedge clk) disable iff (rst)
      !req_valid[h] |=> !resp_valid[h]) else $error("R12 spurious response");

    assert_sc_code_range_R3: assert property (@(posedge clk) disable iff (rst)
      (req_valid[h] && req_op[2*h +: 2] == 2'b11) |=> (resp_data[h*DW +: DW] <= 1))
      else $error("R3 bad commit code");

    assert_clear_drops_resv_R6: assert property (@(posedge clk) disable iff (rst)
      hart_clear[h] |=> !resv_v[h]) else $error("R6 reservation survived clear");

    assert_sc_drops_own_resv_R8: assert property (@(posedge clk) disable iff (rst)
      (req_valid[h] && req_op[2*h +: 2] == 2'b11) |=> !resv_v[h])
      else $error("R8 reservation survived commit");

    assert_win_needs_resv_R2: assert property (@(posedge clk) disable iff (rst)
      sc_win[h] |-> (req_valid[h] && req_op[2*h +: 2] == 2'b11 && resv_v[h]))
      else $error("R2 commit without reservation");

    for (genvar g = h + 1; g < HARTS; g++) begin : g_pair
      assert_single_winner_R9: assert property (@(posedge clk) disable iff (rst)
        !(sc_win[h] && sc_win[g] &&
          ((req_addr[h*AW +: AW] >> BLK_BITS) == (req_addr[g*AW +: AW] >> BLK_BITS))))
        else $error("R9 two winners on one block");
    end
  end
endmodule

bind lrsc_monitor lrsc_monitor_chk #(
  .HARTS(HARTS), .AW(AW), .DW(DW), .BLK_BITS(BLK_BITS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_addr   (req_addr),
  .hart_clear (hart_clear),
  .resp_valid (resp_valid),
  .resp_data  (resp_data),
  .sc_win     (sc_win),
  .resv_v     (resv_v)
);

// File: tb/lrsc_monitor_test.sv
module lrsc_monitor_test;
  localparam int H  = 4;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int BB = 2;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LR = 2'b10, SC = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [H-1:0]       req_valid;
  logic [2*H-1:0]     req_op;
  logic [AW*H-1:0]    req_addr;
  logic [DW*H-1:0]    req_wdata;
  logic [H-1:0]       hart_clear;
  logic               inval_valid;
  logic [AW-BB-1:0]   inval_blk;
  logic [H-1:0]       resp_valid;
  logic [DW*H-1:0]    resp_data;

  logic              bv [H];
  logic [1:0]        bop[H];
  logic [AW-1:0]     ba [H];
  logic [DW-1:0]     bd [H];
  logic              bclr[H];

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int h = 0; h < H; h++) begin
      req_valid[h]           = bv[h];
      req_op[2*h +: 2]       = bop[h];
      req_addr[h*AW +: AW]   = ba[h];
      req_wdata[h*DW +: DW]  = bd[h];
      hart_clear[h]          = bclr[h];
    end
  end

  lrsc_monitor #(.HARTS(H), .AW(AW), .DW(DW), .BLK_BITS(BB)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .hart_clear(hart_clear),
    .inval_valid(inval_valid), .inval_blk(inval_blk),
    .resp_valid(resp_valid), .resp_data(resp_data)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_reqs();
    for (int h = 0; h < H; h++) begin
      bv[h] = 0; bop[h] = LD; ba[h] = '0; bd[h] = '0; bclr[h] = 0;
    end
    inval_valid = 0;
    inval_blk   = '0;
  endtask

  task automatic set_req(input int h, input logic [1:0] o, input int a, input logic [DW-1:0] d);
    bv[h] = 1; bop[h] = o; ba[h] = AW'(a); bd[h] = d;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] rsp(input int h);
    return resp_data[h*DW +: DW];
  endfunction

  task automatic single(input int h, input logic [1:0] o, input int a,
                        input logic [DW-1:0] d, output logic [DW-1:0] r);
    clear_reqs();
    set_req(h, o, a, d);
    tick();
    r = rsp(h);
    clear_reqs();
  endtask

  initial begin
    logic [DW-1:0] r;
    clear_reqs();
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    // R12: no response after reset
    check("R12 reset resp_valid", {28'd0, resp_valid}, '0);

    // R3 / R12: commit right after reset fails
    single(1, SC, 5, 32'hdead, r);
    check("R3 sc after reset", r, 1);

    // R12: store produces a response with data 0
    clear_reqs(); set_req(2, ST, 9, 32'h55); tick();
    check("R12 store resp_valid", {31'd0, resp_valid[2]}, 1);
    check("R12 store data", rsp(2), 0);
    clear_reqs();

    // R1 / R2: every hart, every word
    for (int h = 0; h < H; h++) begin
      for (int w = 0; w < (1 << AW); w++) begin
        logic [DW-1:0] p1, p2;
        p1 = 32'h1000_0000 + h * 256 + w;
        p2 = ~p1;
        single(h, ST, w, p1, r);
        single(h, LR, w, 0, r);
        check("R1 lr data", r, p1);
        single(h, SC, w, p2, r);
        check("R2 sc success", r, 0);
        single(h, LD, w, 0, r);
        check("R2 sc wrote", r, p2);
      end
    end

    // R5 / R4: foreign store to any word of the reserved block
    for (int h = 0; h < H; h++) begin
      for (int g = 0; g < H; g++) begin
        if (g != h) begin
          for (int off = 0; off < 4; off++) begin
            int base;
            base = 4 * ((h * 4 + g) % 16);
            single(h, ST, base, 32'hA0 + off, r);
            single(h, LR, base, 0, r);
            single(g, ST, base + off, 32'hB0 + off, r);
            single(h, SC, base, 32'hC0, r);
            check("R5 foreign store kills", r, 1);
            single(h, LD, base, 0, r);
            check("R5 memory untouched by failed sc", r, (off == 0) ? 32'hB0 : 32'hA0 + off);
          end
        end
      end
    end

    // R5: foreign successful commit kills reservation
    single(0, LR, 16, 0, r);
    single(1, LR, 17, 0, r);
    single(1, SC, 17, 32'h111, r);
    check("R5 other sc succeeds", r, 0);
    single(0, SC, 16, 32'h222, r);
    check("R5 sc after foreign sc", r, 1);

    // R4: block granularity for the owner
    for (int off = 0; off < 4; off++) begin
      single(0, LR, 8, 0, r);
      single(0, SC, 8 + off, 32'h4400 + off, r);
      check("R4 same block sc", r, 0);
      single(0, LD, 8 + off, 0, r);
      check("R4 same block data", r, 32'h4400 + off);
    end

    // R3: wrong block fails and leaves memory
    single(2, ST, 36, 32'h36, r);
    single(2, LR, 32, 0, r);
    single(2, SC, 36, 32'h99, r);
    check("R3 wrong block sc", r, 1);
    single(2, LD, 36, 0, r);
    check("R3 memory unchanged", r, 32'h36);

    // R6: clear pulse alone, then clear in same cycle as commit
    single(3, LR, 44, 0, r);
    clear_reqs(); bclr[3] = 1; tick(); clear_reqs();
    single(3, SC, 44, 1, r);
    check("R6 clear then sc", r, 1);
    single(3, LR, 44, 0, r);
    clear_reqs(); set_req(3, SC, 44, 2); bclr[3] = 1; tick();
    check("R6 clear same cycle", rsp(3), 1);
    clear_reqs();

    // R7: invalidation of matching and other block
    single(1, LR, 20, 0, r);
    clear_reqs(); inval_valid = 1; inval_blk = 4'(22 >> 2); tick(); clear_reqs();
    single(1, SC, 20, 3, r);
    check("R7 matching inval", r, 1);
    single(1, LR, 20, 0, r);
    clear_reqs(); inval_valid = 1; inval_blk = 4'(40 >> 2); tick(); clear_reqs();
    single(1, SC, 20, 4, r);
    check("R7 other-block inval", r, 0);

    // R8: commit clears own reservation after success and after failure
    single(2, LR, 24, 0, r);
    single(2, SC, 24, 5, r);
    check("R8 first sc", r, 0);
    single(2, SC, 24, 6, r);
    check("R8 second sc", r, 1);
    single(2, LR, 24, 0, r);
    single(2, SC, 28, 7, r);
    check("R8 failed sc", r, 1);
    single(2, SC, 24, 8, r);
    check("R8 sc after failed sc", r, 1);

    // R9: four harts commit to one block together
    clear_reqs();
    for (int h = 0; h < H; h++) set_req(h, LR, 12 + h, 0);
    tick(); clear_reqs();
    for (int h = 0; h < H; h++) set_req(h, SC, 12, 32'h900 + h);
    tick();
    for (int h = 0; h < H; h++) check("R9 priority", rsp(h), (h == 0) ? 0 : 1);
    clear_reqs();
    single(3, LD, 12, 0, r);
    check("R9 winner data", r, 32'h900);
    clear_reqs();
    for (int h = 1; h < H; h++) set_req(h, LR, 12, 0);
    tick(); clear_reqs();
    for (int h = 1; h < H; h++) set_req(h, SC, 13, 32'hA00 + h);
    tick();
    for (int h = 1; h < H; h++) check("R9 priority without hart0", rsp(h), (h == 1) ? 0 : 1);
    clear_reqs();

    // R10: own plain store clears own reservation
    single(0, LR, 48, 0, r);
    single(0, ST, 49, 32'h49, r);
    single(0, SC, 48, 32'h48, r);
    check("R10 own store kills", r, 1);

    // R11: load-reserved writes nothing
    single(1, ST, 52, 32'h5252, r);
    for (int k = 0; k < 3; k++) single(k, LR, 52, 32'hFFFF, r);
    single(3, LD, 52, 0, r);
    check("R11 lr no write", r, 32'h5252);

    // R13: store racing a commit on same block; colliding stores
    single(0, ST, 30, 32'h3030, r);
    single(0, LR, 30, 0, r);
    clear_reqs(); set_req(0, SC, 30, 32'h77); set_req(1, ST, 28, 32'h2828); tick();
    check("R13 racing store kills sc", rsp(0), 1);
    clear_reqs();
    single(2, LD, 30, 0, r);
    check("R13 word kept", r, 32'h3030);
    single(2, LD, 28, 0, r);
    check("R13 store landed", r, 32'h2828);
    clear_reqs(); set_req(3, ST, 50, 32'h33); set_req(2, ST, 50, 32'h22); tick(); clear_reqs();
    single(0, LD, 50, 0, r);
    check("R13 lowest store wins", r, 32'h22);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule